// File: doc/BRIEF.md
# DDR3 Bank and Device State Tracker

This block watches the already-decoded command stream sent to an eight-bank DDR3 device. For each bank it keeps track of whether a row is open. For the device as a whole it keeps track of normal operation, power-down, self-refresh and refresh. Every accepted command updates these records one clock later. A command that would be illegal for the current state raises a one-cycle error pulse together with a code that identifies the rule that was broken. A rejected command does not change any state.

Two address bits change meaning with the command:

- On reads and writes, A10 requests automatic precharge and A12 selects a chopped burst of four.
- On precharge, A10 selects all banks instead of one.

Clock enable picks the low-power state. With no row open, the device goes to precharge power-down. With at least one row open, it goes to active power-down. The tracker records which of the two was entered. Timing counters and the data path are out of scope. The only timers are a fixed auto-precharge delay and a fixed refresh length, both given as parameters.

Top module: `bank_cmd_tracker`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, the following are all zero: every bank open bit, every pending bit, `dev_state` (0 = normal), `pd_with_open`, `bc_pulse`, `err_pulse` and `err_code`. Reset acts asynchronously from any state.
- R2: When `cs_n` is high, the command is treated as NOP (code 0). It changes no bank bit and raises neither pulse.
- R3: Command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5, SRE=6, MRS=7, ZQC=8. In normal state with `cke` high, ACT sets `bank_open[bank]` on the next cycle. ACT to a bank that is already open gives error code 2 and changes nothing.
- R4: RD or WR to a bank without an open row gives error code 1.
- R5: An accepted RD or WR with `a12` low pulses `bc_pulse` for one cycle. With `a12` high it does not.
- R6: An accepted RD or WR with `a10` high sets `ap_pending[bank]` on the next cycle. The bank then closes, and its pending bit clears, exactly AP_DELAY clock edges after the command edge. RD or WR to a pending bank gives error code 5.
- R7: PRE with `a10` low closes only `bank`. PRE with `a10` high closes every bank. Both also clear the pending bits of the banks they close. PRE to an idle bank is legal.
- R8: REF, MRS or ZQC while any bank is open gives error code 3. REF with all banks idle enters refresh (`dev_state` 3) for REF_CYCLES cycles and then returns to normal. Any non-NOP command during refresh gives error code 4.
- R9: In normal state, `cke` low with any command other than SRE enters power-down (`dev_state` 1), and that command is ignored. `pd_with_open` is then 1 if a bank was open, and it is 0 in every other state. While in power-down, commands are ignored. `cke` high returns the device to normal on the next cycle.
- R10: SRE with `cke` low and all banks idle enters self-refresh (`dev_state` 2). SRE with `cke` low and a bank open gives code 3 and the device stays in normal state. SRE with `cke` high gives code 6. Self-refresh is left on the cycle after `cke` is seen high.
- R11: `err_pulse` lasts one cycle per rejected command, and `err_code` is non-zero exactly when `err_pulse` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| cmd | input | 4 | Decoded command code |
| bank | input | 3 | Target bank |
| a10 | input | 1 | Auto-precharge / precharge-all select |
| a12 | input | 1 | Burst length select (low = chop to 4) |
| cke | input | 1 | Clock enable |
| bank_open | output | 8 | One bit per bank, high while a row is open |
| ap_pending | output | 8 | One bit per bank, high while auto-precharge is scheduled |
| dev_state | output | 2 | 0 normal, 1 power-down, 2 self-refresh, 3 refresh |
| pd_with_open | output | 1 | Power-down was entered with a row open |
| bc_pulse | output | 1 | Accepted access used burst chop |
| err_pulse | output | 1 | Illegal command seen |
| err_code | output | 3 | Reason for the error, 0 when none |

## Verification
The hardest case to reach is a bank whose auto-precharge countdown runs out in the same window as other activity on that bank. Examples are a precharge or access arriving in the cycle the timer expires, or the timer finishing during power-down. The directed sequence sets these up by arming a bank and then counting NOPs to the exact edge. A long constrained-random phase follows. It is weighted toward ACT, RD with A10 high, and short `cke` drops, and it repeatedly lands commands on banks whose timers are running. A behavioural model in the bench is compared with every output on every cycle.

// File: rtl/bkt_pkg.sv
package bkt_pkg;

  typedef enum logic [3:0] {
    CMD_NOP = 4'd0,
    CMD_ACT = 4'd1,
    CMD_RD  = 4'd2,
    CMD_WR  = 4'd3,
    CMD_PRE = 4'd4,
    CMD_REF = 4'd5,
    CMD_SRE = 4'd6,
    CMD_MRS = 4'd7,
    CMD_ZQC = 4'd8
  } bkt_cmd_e;

  typedef enum logic [1:0] {
    DS_NORMAL  = 2'd0,
    DS_PDOWN   = 2'd1,
    DS_SREF    = 2'd2,
    DS_REFRESH = 2'd3
  } bkt_dev_e;

  localparam logic [2:0] ERR_NONE    = 3'd0;
  localparam logic [2:0] ERR_CLOSED  = 3'd1;
  localparam logic [2:0] ERR_DBL_ACT = 3'd2;
  localparam logic [2:0] ERR_NOTIDLE = 3'd3;
  localparam logic [2:0] ERR_BUSY    = 3'd4;
  localparam logic [2:0] ERR_APPEND  = 3'd5;
  localparam logic [2:0] ERR_SRE_CKE = 3'd6;

  // Commands that are only legal with every bank idle.
  function automatic logic needs_all_idle(input logic [3:0] c);
    return (c == CMD_REF) || (c == CMD_MRS) || (c == CMD_ZQC);
  endfunction

  // Column access commands.
  function automatic logic is_access(input logic [3:0] c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

endpackage

// File: rtl/bkt_cmd_decode.sv
module bkt_cmd_decode
  import bkt_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                 cs_n,
  input  logic [3:0]           cmd,
  input  logic [BA_W-1:0]      bank,
  input  logic                 a10,
  input  logic                 a12,
  input  logic                 cke,
  input  bkt_dev_e             dev_state,
  input  logic [NUM_BANKS-1:0] bank_open,
  input  logic [NUM_BANKS-1:0] ap_pending,
  output logic [NUM_BANKS-1:0] sel,
  output logic                 ev_act,
  output logic                 ev_arm,
  output logic                 ev_pre_one,
  output logic                 ev_pre_all,
  output logic                 ev_ref,
  output logic                 ev_sref,
  output logic                 ev_pdown,
  output logic                 bc_nxt,
  output logic [2:0]           err_nxt
);

  function automatic logic [NUM_BANKS-1:0] onehot(input logic [BA_W-1:0] b);
    logic [NUM_BANKS-1:0] v;
    v = '0;
    v[b] = 1'b1;
    return v;
  endfunction

  logic [3:0] cmd_v;
  logic       any_open;
  logic       tgt_open;
  logic       tgt_pend;

  assign cmd_v    = cs_n ? 4'(CMD_NOP) : cmd;
  assign sel      = onehot(bank);
  assign any_open = |bank_open;
  assign tgt_open = |(bank_open & sel);
  assign tgt_pend = |(ap_pending & sel);

  always_comb begin
    ev_act     = 1'b0;
    ev_arm     = 1'b0;
    ev_pre_one = 1'b0;
    ev_pre_all = 1'b0;
    ev_ref     = 1'b0;
    ev_sref    = 1'b0;
    ev_pdown   = 1'b0;
    bc_nxt     = 1'b0;
    err_nxt    = ERR_NONE;
    unique case (dev_state)
      DS_NORMAL: begin
        if (!cke) begin
          if (cmd_v == CMD_SRE) begin
            if (any_open) err_nxt = ERR_NOTIDLE;
            else          ev_sref = 1'b1;
          end else begin
            ev_pdown = 1'b1;
          end
        end else if (cmd_v == CMD_ACT) begin
          if (tgt_open) err_nxt = ERR_DBL_ACT;
          else          ev_act  = 1'b1;
        end else if (is_access(cmd_v)) begin
          if (!tgt_open)     err_nxt = ERR_CLOSED;
          else if (tgt_pend) err_nxt = ERR_APPEND;
          else begin
            bc_nxt = !a12;
            ev_arm = a10;
          end
        end else if (cmd_v == CMD_PRE) begin
          ev_pre_all = a10;
          ev_pre_one = !a10;
        end else if (cmd_v == CMD_SRE) begin
          err_nxt = ERR_SRE_CKE;
        end else if (needs_all_idle(cmd_v)) begin
          if (any_open)              err_nxt = ERR_NOTIDLE;
          else if (cmd_v == CMD_REF) ev_ref  = 1'b1;
        end
      end
      DS_REFRESH: begin
        if (cmd_v != CMD_NOP) err_nxt = ERR_BUSY;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bkt_bank_slot.sv
module bkt_bank_slot #(
  parameter int AP_DELAY = 4,
  parameter int CNT_W    = $clog2(AP_DELAY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic ev_act,
  input  logic ev_arm,
  input  logic ev_pre_one,
  input  logic ev_pre_all,
  output logic open_o,
  output logic pend_o
);

  logic [CNT_W-1:0] cnt;
  logic             close_now;

  assign close_now = ev_pre_all || (sel && ev_pre_one);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_o <= 1'b0;
      pend_o <= 1'b0;
      cnt    <= '0;
    end else if (close_now) begin
      open_o <= 1'b0;
      pend_o <= 1'b0;
      cnt    <= '0;
    end else if (sel && ev_act) begin
      open_o <= 1'b1;
    end else if (sel && ev_arm) begin
      pend_o <= 1'b1;
      cnt    <= CNT_W'(AP_DELAY);
    end else if (pend_o) begin
      if (cnt == CNT_W'(1)) begin
        open_o <= 1'b0;
        pend_o <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/bkt_dev_fsm.sv
module bkt_dev_fsm
  import bkt_pkg::*;
#(
  parameter int REF_CYCLES = 6,
  parameter int RC_W       = $clog2(REF_CYCLES + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cke,
  input  logic     any_open,
  input  logic     ev_ref,
  input  logic     ev_sref,
  input  logic     ev_pdown,
  output bkt_dev_e state_o,
  output logic     pd_with_open_o
);

  logic [RC_W-1:0] rcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o        <= DS_NORMAL;
      pd_with_open_o <= 1'b0;
      rcnt           <= '0;
    end else begin
      unique case (state_o)
        DS_NORMAL: begin
          if (ev_ref) begin
            state_o <= DS_REFRESH;
            rcnt    <= RC_W'(REF_CYCLES);
          end else if (ev_sref) begin
            state_o <= DS_SREF;
          end else if (ev_pdown) begin
            state_o        <= DS_PDOWN;
            pd_with_open_o <= any_open;
          end
        end
        DS_PDOWN: begin
          if (cke) begin
            state_o        <= DS_NORMAL;
            pd_with_open_o <= 1'b0;
          end
        end
        DS_SREF: begin
          if (cke) state_o <= DS_NORMAL;
        end
        DS_REFRESH: begin
          if (rcnt == RC_W'(1)) begin
            state_o <= DS_NORMAL;
            rcnt    <= '0;
          end else begin
            rcnt <= rcnt - RC_W'(1);
          end
        end
        default: state_o <= DS_NORMAL;
      endcase
    end
  end

endmodule

// File: rtl/bank_cmd_tracker.sv
module bank_cmd_tracker
  import bkt_pkg::*;
#(
  parameter int NUM_BANKS  = 8,
  parameter int AP_DELAY   = 4,
  parameter int REF_CYCLES = 6,
  localparam int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic [3:0]           cmd,
  input  logic [BA_W-1:0]      bank,
  input  logic                 a10,
  input  logic                 a12,
  input  logic                 cke,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [NUM_BANKS-1:0] ap_pending,
  output logic [1:0]           dev_state,
  output logic                 pd_with_open,
  output logic                 bc_pulse,
  output logic                 err_pulse,
  output logic [2:0]           err_code
);

  logic [NUM_BANKS-1:0] sel;
  logic                 ev_act, ev_arm, ev_pre_one, ev_pre_all;
  logic                 ev_ref, ev_sref, ev_pdown;
  logic                 bc_nxt;
  logic [2:0]           err_nxt;
  bkt_dev_e             ds;

  assign dev_state = ds;

  bkt_cmd_decode #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_dec (
    .cs_n(cs_n), .cmd(cmd), .bank(bank), .a10(a10), .a12(a12), .cke(cke),
    .dev_state(ds), .bank_open(bank_open), .ap_pending(ap_pending),
    .sel(sel), .ev_act(ev_act), .ev_arm(ev_arm), .ev_pre_one(ev_pre_one),
    .ev_pre_all(ev_pre_all), .ev_ref(ev_ref), .ev_sref(ev_sref),
    .ev_pdown(ev_pdown), .bc_nxt(bc_nxt), .err_nxt(err_nxt)
  );

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    bkt_bank_slot #(.AP_DELAY(AP_DELAY)) u_slot (
      .clk(clk), .rst_n(rst_n), .sel(sel[i]), .ev_act(ev_act),
      .ev_arm(ev_arm), .ev_pre_one(ev_pre_one), .ev_pre_all(ev_pre_all),
      .open_o(bank_open[i]), .pend_o(ap_pending[i])
    );
  end

  bkt_dev_fsm #(.REF_CYCLES(REF_CYCLES)) u_dev (
    .clk(clk), .rst_n(rst_n), .cke(cke), .any_open(|bank_open),
    .ev_ref(ev_ref), .ev_sref(ev_sref), .ev_pdown(ev_pdown),
    .state_o(ds), .pd_with_open_o(pd_with_open)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_pulse  <= 1'b0;
      err_pulse <= 1'b0;
      err_code  <= ERR_NONE;
    end else begin
      bc_pulse  <= bc_nxt;
      err_pulse <= (err_nxt != ERR_NONE);
      err_code  <= err_nxt;
    end
  end

endmodule

// File: rtl/bkt_checker.sv
module bkt_checker #(
  parameter int NUM_BANKS = 8,
  parameter int BA_W      = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic [3:0]           cmd,
  input logic [BA_W-1:0]      bank,
  input logic                 cke,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic [NUM_BANKS-1:0] ap_pending,
  input logic [1:0]           dev_state,
  input logic                 bc_pulse,
  input logic                 err_pulse,
  input logic [2:0]           err_code
);

  p_cs_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!err_pulse && !bc_pulse));

  p_dbl_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cmd == 4'd1 && dev_state == 2'd0 && cke && bank_open[bank])
    |=> (err_pulse && err_code == 3'd2));

  p_closed_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && (cmd == 4'd2 || cmd == 4'd3) && dev_state == 2'd0 && cke && !bank_open[bank])
    |=> (err_pulse && err_code == 3'd1));

  p_pend_subset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_pending & ~bank_open) == '0);

  p_refresh_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_state == 2'd3) |-> (bank_open == '0));

  p_pd_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_state == 2'd1 && cke) |=> (dev_state == 2'd0));

  p_sref_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_state == 2'd2) |-> (bank_open == '0));

  p_code_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse == (err_code != 3'd0));

endmodule

bind bank_cmd_tracker bkt_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd(cmd), .bank(bank), .cke(cke),
  .bank_open(bank_open), .ap_pending(ap_pending), .dev_state(dev_state),
  .bc_pulse(bc_pulse), .err_pulse(err_pulse), .err_code(err_code)
);

// File: tb/bank_cmd_tracker_tb_top.sv
module bank_cmd_tracker_tb_top;

  localparam int NB  = 8;
  localparam int APD = 4;
  localparam int REFC = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic [3:0] cmd = 4'd0;
  logic [2:0] bank = 3'd0;
  logic       a10 = 1'b0, a12 = 1'b1, cke = 1'b1;
  logic [7:0] bank_open, ap_pending;
  logic [1:0] dev_state;
  logic       pd_with_open, bc_pulse, err_pulse;
  logic [2:0] err_code;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bank_cmd_tracker #(.NUM_BANKS(NB), .AP_DELAY(APD), .REF_CYCLES(REFC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd(cmd), .bank(bank), .a10(a10),
    .a12(a12), .cke(cke), .bank_open(bank_open), .ap_pending(ap_pending),
    .dev_state(dev_state), .pd_with_open(pd_with_open), .bc_pulse(bc_pulse),
    .err_pulse(err_pulse), .err_code(err_code)
  );

  // Behavioural reference model
  int m_open[NB], m_pend[NB], m_cnt[NB];
  int m_ds, m_rc, m_pd, m_bc, m_err, m_code;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin m_open[i] = 0; m_pend[i] = 0; m_cnt[i] = 0; end
      m_ds = 0; m_rc = 0; m_pd = 0; m_bc = 0; m_err = 0; m_code = 0;
    end else begin
      int c, any, b, act, arm, p1, pall;
      c = cs_n ? 0 : int'(cmd);
      b = int'(bank);
      any = 0;
      for (int i = 0; i < NB; i++) if (m_open[i] != 0) any = 1;
      act = 0; arm = 0; p1 = 0; pall = 0;
      m_bc = 0; m_code = 0;
      if (m_ds == 0) begin
        if (!cke) begin
          if (c == 6) begin
            if (any != 0) m_code = 3; else m_ds = 2;
          end else begin
            m_ds = 1; m_pd = any;
          end
        end else begin
          case (c)
            1: if (m_open[b] != 0) m_code = 2; else act = 1;
            2, 3: begin
              if (m_open[b] == 0) m_code = 1;
              else if (m_pend[b] != 0) m_code = 5;
              else begin m_bc = a12 ? 0 : 1; arm = a10 ? 1 : 0; end
            end
            4: if (a10) pall = 1; else p1 = 1;
            5: if (any != 0) m_code = 3; else begin m_ds = 3; m_rc = REFC; end
            6: m_code = 6;
            7, 8: if (any != 0) m_code = 3;
            default: ;
          endcase
        end
      end else if (m_ds == 1) begin
        if (cke) begin m_ds = 0; m_pd = 0; end
      end else if (m_ds == 2) begin
        if (cke) m_ds = 0;
      end else begin
        if (c != 0) m_code = 4;
        if (m_rc == 1) m_ds = 0; else m_rc = m_rc - 1;
      end
      m_err = (m_code != 0) ? 1 : 0;
      for (int i = 0; i < NB; i++) begin
        if (pall != 0 || (p1 != 0 && i == b)) begin m_open[i] = 0; m_pend[i] = 0; end
        else if (act != 0 && i == b) m_open[i] = 1;
        else if (arm != 0 && i == b) begin m_pend[i] = 1; m_cnt[i] = APD; end
        else if (m_pend[i] != 0) begin
          if (m_cnt[i] == 1) begin m_open[i] = 0; m_pend[i] = 0; end
          else m_cnt[i] = m_cnt[i] - 1;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  function automatic int mvec(input int sel);
    int v;
    v = 0;
    for (int i = 0; i < NB; i++)
      if ((sel == 0 ? m_open[i] : m_pend[i]) != 0) v |= (1 << i);
    return v;
  endfunction

  task automatic compare_all();
    chk("R3", "bank_open", int'(bank_open), mvec(0));
    chk("R6", "ap_pending", int'(ap_pending), mvec(1));
    chk("R8", "dev_state", int'(dev_state), m_ds);
    chk("R9", "pd_with_open", int'(pd_with_open), m_pd);
    chk("R5", "bc_pulse", int'(bc_pulse), m_bc);
    chk("R11", "err_pulse", int'(err_pulse), m_err);
    chk("R4", "err_code", int'(err_code), m_code);
  endtask

  task automatic step(input bit cs, input int c, input int b, input bit x10,
                      input bit x12, input bit ck);
    @(negedge clk);
    compare_all();
    cs_n = cs; cmd = 4'(c); bank = 3'(b); a10 = x10; a12 = x12; cke = ck;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic go(input int c, input int b, input bit x10, input bit x12);
    step(1'b0, c, b, x10, x12, 1'b1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog expired, run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "open in reset", int'(bank_open), 0);
    rst_n = 1'b1;
    nop(1);
    chk("R1", "state after reset", int'({dev_state, err_pulse, bc_pulse, pd_with_open}), 0);

    go(1, 2, 0, 1); go(1, 5, 0, 1); go(1, 2, 0, 1); nop(1);
    chk("R3", "err code double act", int'(err_code), 2);
    chk("R3", "open after acts", int'(bank_open), 8'h24);
    step(1'b1, 1, 3, 0, 1, 1); nop(1);
    chk("R2", "masked act", int'(bank_open), 8'h24);
    go(2, 3, 0, 1); nop(1);
    chk("R4", "read closed bank", int'(err_code), 1);
    go(3, 2, 0, 0); nop(1);
    chk("R5", "chop pulse", int'(bc_pulse), 1);
    go(2, 5, 0, 1); nop(1);
    chk("R5", "no chop", int'(bc_pulse), 0);

    go(2, 2, 1, 1); go(2, 2, 0, 1);
    chk("R6", "pending set", int'(ap_pending), 8'h04);
    nop(1);
    chk("R6", "access to pending", int'(err_code), 5);
    nop(4);
    chk("R6", "auto closed", int'(bank_open), 8'h20);

    go(5, 0, 0, 1); go(7, 0, 0, 1); nop(1);
    chk("R8", "mrs with open", int'(err_code), 3);
    go(4, 5, 0, 1); go(1, 1, 0, 1); go(1, 6, 0, 1); go(3, 6, 1, 1);
    go(4, 0, 1, 1); nop(1);
    chk("R7", "precharge all", int'({bank_open, ap_pending}), 0);

    go(5, 0, 0, 1); go(1, 4, 0, 1); nop(1);
    chk("R8", "refresh state", int'(dev_state), 3);
    chk("R8", "busy error", int'(err_code), 4);
    nop(REFC);
    chk("R8", "refresh done", int'(dev_state), 0);

    go(1, 0, 0, 1); step(1'b0, 0, 0, 0, 1, 0); step(1'b0, 1, 4, 0, 1, 0);
    chk("R9", "active pd", int'({dev_state, pd_with_open}), 3'b011);
    nop(2);
    chk("R9", "pd exit open kept", int'(bank_open), 8'h01);
    go(4, 0, 1, 1); step(1'b0, 0, 0, 0, 1, 0); step(1'b0, 0, 0, 0, 1, 0);
    chk("R9", "precharge pd", int'({dev_state, pd_with_open}), 3'b010);
    nop(2);

    go(6, 0, 0, 1); step(1'b0, 6, 0, 0, 1, 0);
    chk("R10", "sre with cke high", int'(err_code), 6);
    step(1'b0, 0, 0, 0, 1, 0); step(1'b0, 0, 0, 0, 1, 0);
    chk("R10", "in self-refresh", int'(dev_state), 2);
    nop(2);
    chk("R10", "self-refresh exit", int'(dev_state), 0);
    go(1, 3, 0, 1); step(1'b0, 6, 0, 0, 1, 0); nop(1);
    chk("R10", "sre with open", int'({dev_state, err_code}), 5'b00011);
    go(4, 0, 1, 1);

    // Race the auto-precharge expiry against a precharge and against power-down.
    go(1, 7, 0, 1); go(2, 7, 1, 1); nop(APD - 1); go(4, 7, 0, 1); nop(2);
    go(1, 6, 0, 1); go(3, 6, 1, 0); step(1'b0, 0, 0, 0, 1, 0);
    step(1'b0, 0, 0, 0, 1, 0); step(1'b0, 0, 0, 0, 1, 0); step(1'b0, 0, 0, 0, 1, 0);
    nop(3);

    for (int k = 0; k < 4000; k++) begin
      int r, c;
      r = int'($urandom_range(0, 99));
      if (r < 25) c = 1; else if (r < 55) c = 2 + int'($urandom_range(0, 1));
      else if (r < 70) c = 4; else if (r < 78) c = 5 + int'($urandom_range(0, 3));
      else c = 0;
      step($urandom_range(0, 9) == 0, c, int'($urandom_range(0, 7)),
           $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 11) != 0);
      if (k == 2000) begin
        rst_n = 1'b0;
        #1;
        chk("R1", "mid-run reset", int'({bank_open, ap_pending, dev_state}), 0);
        @(negedge clk);
        rst_n = 1'b1;
      end
    end
    nop(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule